// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block keeps the I/O address windows of a PCI-to-CardBus bridge and decides, for every I/O access, whether it crosses the bridge. It holds a number of windows, two by default. Each window has a lower-bound register and an upper-bound register. Software programs them through a small configuration port: a 32-bit write with byte enables, a byte offset to select the register, and a 32-bit read-back. Two control inputs set the value of the two read-only low bits of all lower-bound registers and of all upper-bound registers, respectively.

Every window lies in the first 64 KB page of the 32-bit I/O space and has doubleword granularity. A window is live once either of its bounds is nonzero. The decode side is purely combinational. It takes an I/O address and the side the access came from, and it returns one hit flag per window plus a single forward flag. An access from the PCI side is forwarded when it hits any live window. An access from the CardBus side is forwarded when it hits none.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, all stored bound fields are zero. Every window is disabled, so `win_hit` is 0 for every address.
- R2: Window w has its lower bound at byte offset 2Ch+8*w and its upper bound at 30h+8*w (2Ch, 30h, 34h, 38h for two windows). Any other offset reads as 0, and a write to it changes no register.
- R3: Bits 31:16 of every bound register read as zero. Writing them has no effect.
- R4: Bits 15:2 of each bound register are writable. `cfg_be[0]` enables the update of bits 7:2, `cfg_be[1]` enables the update of bits 15:8, and `cfg_be[3:2]` have no effect. A written value is visible from the cycle after the write edge.
- R5: Bits 1:0 of a lower-bound register read 01b when `base_lo_sel` is 1 and 00b otherwise. Bits 1:0 of an upper-bound register follow `limit_lo_sel` in the same way.
- R6: A window is enabled exactly when its lower-bound bits 15:2 or its upper-bound bits 15:2 are nonzero. A window with lower bound 0 and a nonzero upper bound therefore covers address 0.
- R7: An address hits an enabled window when its bits 31:16 are zero and its bits 15:2 lie between the lower and upper bound, both bounds inclusive. Address bits 1:0 are ignored.
- R8: An enabled window whose lower bound is greater than its upper bound matches no address.
- R9: With `io_from_cb`=0 (PCI side), `fwd` is 1 when any window hits. With `io_from_cb`=1 (CardBus side), `fwd` is 1 when no window hits.
- R10: `cfg_rdata`, `win_hit` and `fwd` are combinational in the same cycle as their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_off` |
| base_lo_sel | input | 1 | Sets bits 1:0 of lower-bound reads to 01b |
| limit_lo_sel | input | 1 | Sets bits 1:0 of upper-bound reads to 01b |
| io_addr | input | 32 | I/O address to decode |
| io_from_cb | input | 1 | 0: access from PCI side, 1: from CardBus side |
| win_hit | output | 2 | Per-window hit flags |
| fwd | output | 1 | Forward the access across the bridge |

## Verification
The read-back and both decode outputs are due in the same cycle as the offset, address and direction that produce them. A register write takes effect one rising edge after it is presented. The bench drives all inputs just after the falling edge and samples a short delay later, still before the next rising edge. Write results are checked at the falling edge that follows the capturing edge. One check drives a write and samples the decode before that edge, which shows that the old bounds still apply in that cycle.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
    localparam int DW_BITS    = 14;
    localparam int BASE_OFF0  = 8'h2C;
    localparam int LIMIT_OFF0 = 8'h30;
    localparam int WIN_STRIDE = 8;
    typedef logic [DW_BITS-1:0] dw_t;
endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
    import iowin_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [7:0]              off,
    input  logic [3:0]              be,
    input  logic [31:0]             wdata,
    input  logic                    base_sel,
    input  logic                    limit_sel,
    output logic [31:0]             rdata,
    output logic [NUM_WIN-1:0][DW_BITS-1:0] base_q,
    output logic [NUM_WIN-1:0][DW_BITS-1:0] limit_q
);
    logic [NUM_WIN-1:0] sel_b;
    logic [NUM_WIN-1:0] sel_l;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [7:0] OFF_B = 8'(BASE_OFF0 + WIN_STRIDE * w);
        localparam logic [7:0] OFF_L = 8'(LIMIT_OFF0 + WIN_STRIDE * w);
        dw_t b_r;
        dw_t l_r;

        assign sel_b[w] = (off == OFF_B);
        assign sel_l[w] = (off == OFF_L);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                b_r <= '0;
                l_r <= '0;
            end else if (wr) begin
                if (sel_b[w] && be[0]) b_r[5:0]  <= wdata[7:2];
                if (sel_b[w] && be[1]) b_r[13:6] <= wdata[15:8];
                if (sel_l[w] && be[0]) l_r[5:0]  <= wdata[7:2];
                if (sel_l[w] && be[1]) l_r[13:6] <= wdata[15:8];
            end
        end

        assign base_q[w]  = b_r;
        assign limit_q[w] = l_r;
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (sel_b[w]) rdata = {16'h0000, base_q[w], 1'b0, base_sel};
            if (sel_l[w]) rdata = {16'h0000, limit_q[w], 1'b0, limit_sel};
        end
    end

    logic mapped;
    assign mapped = |{sel_b, sel_l};

    a_r2_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> ($stable(base_q) && $stable(limit_q)));

    a_r4_no_low_be_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && be[1:0] == 2'b00) |=> ($stable(base_q) && $stable(limit_q)));

    a_r5_base_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b[0]) |-> (rdata[1:0] == {1'b0, base_sel}));

    a_r3_upper_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[31:16] == 16'h0000);
endmodule

// File: rtl/iowin_match.sv
module iowin_match
    import iowin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  dw_t         lo,
    input  dw_t         hi,
    input  logic [31:0] addr,
    output logic        hit
);
    logic live;
    logic in_page;
    logic above_lo;
    logic below_hi;

    assign live     = (lo != '0) || (hi != '0);
    assign in_page  = (addr[31:16] == 16'h0000);
    assign above_lo = (addr[15:2] >= lo);
    assign below_hi = (addr[15:2] <= hi);
    assign hit      = live && in_page && above_lo && below_hi;

    a_r7_outside_page_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[31:16] != 16'h0000) |-> !hit);

    a_r8_inverted_bounds_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (lo > hi) |-> !hit);

    a_r6_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (lo == '0 && hi == '0) |-> !hit);
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [7:0]         cfg_off,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               base_lo_sel,
    input  logic               limit_lo_sel,
    input  logic [31:0]        io_addr,
    input  logic               io_from_cb,
    output logic [NUM_WIN-1:0] win_hit,
    output logic               fwd
);
    logic [NUM_WIN-1:0][DW_BITS-1:0] base_q;
    logic [NUM_WIN-1:0][DW_BITS-1:0] limit_q;

    iowin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .off       (cfg_off),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .base_sel  (base_lo_sel),
        .limit_sel (limit_lo_sel),
        .rdata     (cfg_rdata),
        .base_q    (base_q),
        .limit_q   (limit_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        iowin_match u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .lo    (base_q[w]),
            .hi    (limit_q[w]),
            .addr  (io_addr),
            .hit   (win_hit[w])
        );
    end

    logic any_hit;
    assign any_hit = |win_hit;
    assign fwd     = io_from_cb ? !any_hit : any_hit;

    a_r9_cardbus_hit_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (io_from_cb && any_hit) |-> !fwd);

    a_r9_pci_miss_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_from_cb && !any_hit) |-> !fwd);

    a_r1_cleared_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (win_hit == '0));
endmodule

// File: tb/test_iowin_decoder.sv
module test_iowin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_off = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        base_lo_sel = 1'b0;
    logic        limit_lo_sel = 1'b0;
    logic [31:0] io_addr = '0;
    logic        io_from_cb = 1'b0;
    logic [1:0]  win_hit;
    logic        fwd;

    int n_tests = 0;
    int n_fail  = 0;
    logic [13:0] mb [2];
    logic [13:0] ml [2];

    always #4 clk = ~clk;

    iowin_decoder i_iowin_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .base_lo_sel(base_lo_sel), .limit_lo_sel(limit_lo_sel),
        .io_addr(io_addr), .io_from_cb(io_from_cb),
        .win_hit(win_hit), .fwd(fwd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] off);
        logic [31:0] r = '0;
        for (int w = 0; w < 2; w++) begin
            if (off == 8'(8'h2C + 8 * w)) r = {16'h0, mb[w], 1'b0, base_lo_sel};
            if (off == 8'(8'h30 + 8 * w)) r = {16'h0, ml[w], 1'b0, limit_lo_sel};
        end
        return r;
    endfunction

    function automatic logic exp_hit1(input int w, input logic [31:0] a);
        logic live = (mb[w] != 0) || (ml[w] != 0);
        return live && (a[31:16] == 0) && (a[15:2] >= mb[w]) && (a[15:2] <= ml[w]);
    endfunction

    function automatic logic [1:0] exp_hit(input logic [31:0] a);
        return {exp_hit1(1, a), exp_hit1(0, a)};
    endfunction

    task automatic wr_reg(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = off; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0;
        for (int w = 0; w < 2; w++) begin
            if (off == 8'(8'h2C + 8 * w)) begin
                if (be[0]) mb[w][5:0]  = d[7:2];
                if (be[1]) mb[w][13:6] = d[15:8];
            end
            if (off == 8'(8'h30 + 8 * w)) begin
                if (be[0]) ml[w][5:0]  = d[7:2];
                if (be[1]) ml[w][13:6] = d[15:8];
            end
        end
    endtask

    task automatic chk_read(input string req, input logic [7:0] off);
        cfg_off = off; #1;
        chk(req, cfg_rdata, exp_read(off));
    endtask

    task automatic chk_all_regs(input string req);
        for (int i = 0; i < 4; i++) chk_read(req, 8'(8'h2C + 4 * i));
    endtask

    task automatic chk_dec(input string req, input logic [31:0] a, input logic dir);
        logic [1:0] eh;
        io_addr = a; io_from_cb = dir; #1;
        eh = exp_hit(a);
        chk(req, {30'h0, win_hit}, {30'h0, eh});
        chk("R9", {31'h0, fwd}, {31'h0, dir ? (eh == 2'b00) : (eh != 2'b00)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int w = 0; w < 2; w++) begin mb[w] = '0; ml[w] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_all_regs("R1");
        chk_dec("R1", 32'h0000_0000, 1'b0);
        chk_dec("R1", 32'h0000_1234, 1'b0);

        // R5: low bits follow select inputs
        base_lo_sel = 1'b1; chk_read("R5", 8'h2C); chk_read("R5", 8'h30);
        limit_lo_sel = 1'b1; chk_read("R5", 8'h38); chk_read("R5", 8'h34);
        base_lo_sel = 1'b0; chk_read("R5", 8'h34);
        limit_lo_sel = 1'b0;

        // R3: upper half not writable
        wr_reg(8'h2C, 32'hFFFF_0000, 4'hF);
        chk_all_regs("R3");
        chk_dec("R3", 32'h0000_0000, 1'b0);

        // R2: unmapped offsets
        wr_reg(8'h28, 32'h0000_FFFC, 4'hF);
        wr_reg(8'h3C, 32'h0000_FFFC, 4'hF);
        wr_reg(8'h2D, 32'h0000_FFFC, 4'hF);
        chk_all_regs("R2");
        chk_read("R2", 8'h28); chk_read("R2", 8'h3C);

        // R4: byte enables
        wr_reg(8'h30, 32'hFFFF_FFFF, 4'b1100);
        chk_read("R4", 8'h30);
        wr_reg(8'h30, 32'h0000_12FC, 4'b0001);
        chk_read("R4", 8'h30);
        wr_reg(8'h30, 32'h0000_12FC, 4'b0010);
        chk_read("R4", 8'h30);

        // R6: base zero, nonzero limit covers address 0
        chk_dec("R6", 32'h0000_0000, 1'b0);
        chk_dec("R6", 32'h0000_12FF, 1'b0);
        chk_dec("R7", 32'h0000_1300, 1'b0);
        chk_dec("R7", 32'h0001_0000, 1'b0);

        // R8: base above limit
        wr_reg(8'h2C, 32'h0000_2000, 4'h3);
        chk_dec("R8", 32'h0000_2000, 1'b0);
        chk_dec("R8", 32'h0000_12FC, 1'b1);
        // base nonzero, limit zero: enabled but inverted
        wr_reg(8'h30, 32'h0, 4'h3);
        chk_dec("R6", 32'h0000_2000, 1'b0);

        // window 1 inclusive bounds
        wr_reg(8'h34, 32'h0000_0400, 4'h3);
        wr_reg(8'h38, 32'h0000_04FC, 4'h3);
        chk_dec("R7", 32'h0000_03FF, 1'b0);
        chk_dec("R7", 32'h0000_0400, 1'b0);
        chk_dec("R7", 32'h0000_04FF, 1'b1);
        chk_dec("R7", 32'h0000_0500, 1'b1);
        chk_dec("R7", 32'h8000_0400, 1'b0);

        // R10: decode keeps old bounds until the write edge
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = 8'h38; cfg_wdata = 32'h0000_08FC; cfg_be = 4'h3;
        io_addr = 32'h0000_0600; io_from_cb = 1'b0; #1;
        chk("R10", {30'h0, win_hit}, 32'h0);
        @(negedge clk);
        cfg_wr = 1'b0; ml[1] = 14'(32'h08FC >> 2);
        chk_dec("R10", 32'h0000_0600, 1'b0);

        // random mix
        for (int it = 0; it < 300; it++) begin
            logic [7:0] off;
            logic [31:0] d;
            logic [31:0] a;
            int k;
            off = 8'(8'h2C + 4 * ($urandom % 4));
            if (($urandom % 8) == 0) off = 8'($urandom);
            d = $urandom & 32'h0003_FFFF;
            wr_reg(off, d, 4'($urandom));
            base_lo_sel = 1'($urandom); limit_lo_sel = 1'($urandom);
            chk_read("R4", off);
            for (int j = 0; j < 4; j++) begin
                k = $urandom % 5;
                case (k)
                    0: a = {16'h0, mb[j % 2], 2'($urandom)};
                    1: a = {16'h0, ml[j % 2], 2'($urandom)};
                    2: a = {16'h0, mb[j % 2] - 14'd1, 2'b11};
                    3: a = {16'h0, ml[j % 2] + 14'd1, 2'b00};
                    default: a = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFFF);
                endcase
                chk_dec("R7", a, 1'($urandom));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule